// File: doc/BRIEF.md
# DRAM Bank Activation Timing Tracker

This block holds the timing state of every bank in every rank of one DRAM channel. A scheduler tells it about each command it issues: an activate, a precharge or a column (read/write) burst. Each command carries its issue time in controller cycles. From these the block keeps, per bank, the earliest time at which another activate, a precharge or a column command may go out, together with the open row and a count of column accesses to that row. A query port reads the state of any one bank and the active-bank count of its rank, so the scheduler can compare these times with its own clock.

Activates are spaced by a short or a long row-to-row delay, depending on whether the two banks share a bank group. A per-rank window of the last few activate times limits how many activates fall inside a rolling interval. Column bursts push out the column-allowed time of every bank on the channel, with extra spacing for a burst in the same bank group and for a switch between ranks. Illegal sequences are reported on two one-cycle flags. Commands enter as a plain valid-qualified word, one per cycle, with no back-pressure: the tracker accepts every command that is presented.

Top module: `dram_bank_timer`

## Requirements
- R1: After reset every bank reads allowed times of 0, no open row, access count 0; every rank count is 0 and both error flags are low.
- R2: Two banks share a bank group when grouping is enabled and their indices are equal modulo NBG; when grouping is disabled, no pair of banks counts as sharing a group.
- R3: An activate (op 2'b01) to a closed bank opens it, stores the row, clears its access count, sets its precharge-allowed time to t+T_RAS and raises its column-allowed time to at least t+T_RCD.
- R4: An accepted activate raises the activate-allowed time of every bank in the same rank to at least t+T_RRD_L for a bank sharing the group, otherwise t+T_RRD; banks of other ranks are unchanged.
- R5: Each rank keeps the last XN activate times; an activate drops the oldest and inserts t at the front. If the new oldest is nonzero and less than T_XAW before t, every bank in the rank gets activate-allowed of at least that oldest time plus T_XAW.
- R6: If, before the shift, the oldest window entry is nonzero and less than T_XAW before t, act_window_err is high for one cycle; the activate is still applied.
- R7: A column command (op 2'b11) raises column-allowed of every bank of every rank to at least t plus T_CCD_L (same rank, shared group), T_BURST (same rank, other group) or T_BURST+T_CS (other rank), and increments the addressed bank's access count modulo 2^ACCW.
- R8: A precharge (op 2'b10) to an open bank closes it, raises its activate-allowed time to at least t+T_RP and lowers the rank's count by one.
- R9: An activate to an open bank or a precharge to a closed bank raises seq_err for one cycle and changes no state.
- R10: The rank count equals the number of open banks in that rank and never exceeds NB.
- R11: With cmd_valid low, or with op 2'b00, no state changes and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 none, 01 activate, 10 precharge, 11 column |
| cmd_rank | input | RW | Target rank |
| cmd_bank | input | BW | Target bank within the rank |
| cmd_row | input | ROWW | Row for an activate |
| cmd_time | input | TW | Issue time of the command |
| q_rank | input | RW | Rank to read |
| q_bank | input | BW | Bank to read |
| q_act_at | output | TW | Earliest activate time of the queried bank |
| q_pre_at | output | TW | Earliest precharge time of the queried bank |
| q_col_at | output | TW | Earliest column time of the queried bank |
| q_row | output | ROWW | Open row of the queried bank |
| q_open | output | 1 | Queried bank has an open row |
| q_acc | output | ACCW | Column accesses since the last activate |
| q_nact | output | CW | Open-bank count of the queried rank |
| seq_err | output | 1 | Illegal activate or precharge, one cycle |
| act_window_err | output | 1 | Rolling activate window exceeded, one cycle |

## Verification
Every command is registered at the clock edge where cmd_valid is seen, so all bank state, rank counts and both error flags change at that edge and read back one cycle after the command; the query port is combinational over that state. The bench drives a command half a cycle before an edge, waits for that edge and the following falling edge, drops cmd_valid, and only then compares the flags and the queried bank against its reference model. Flags are thus seen for exactly the cycle after the command that caused them, and the next command is applied from the same falling edge.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ACT  = 2'b01,
    OP_PRE  = 2'b10,
    OP_COL  = 2'b11
  } dbt_op_e;
endpackage

// File: rtl/dbt_window.sv
// Per-rank record of the most recent activate times.
module dbt_window #(
  parameter int TW    = 20,
  parameter int XN    = 4,
  parameter int T_XAW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [TW-1:0] t,
  output logic          hit,
  output logic [TW-1:0] floor_at,
  output logic          viol
);
  localparam logic [TW-1:0] XAW_W = TW'(T_XAW);

  logic [TW-1:0] win_q [XN];
  logic [TW-1:0] oldest, next_old;

  assign oldest   = win_q[XN-1];
  assign next_old = win_q[XN-2];
  assign viol     = push && (oldest != '0) && ((t - oldest) < XAW_W);
  assign hit      = (next_old != '0) && ((t - next_old) < XAW_W);
  assign floor_at = next_old + XAW_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < XN; i++) win_q[i] <= '0;
    end else if (push) begin
      win_q[0] <= t;
      for (int i = 1; i < XN; i++) win_q[i] <= win_q[i-1];
    end
  end

  p_win_front_r5: assert property (@(posedge clk) disable iff (rst)
    push |=> win_q[0] == $past(t));
endmodule

// File: rtl/dbt_bank.sv
// Timing state of a single bank.
module dbt_bank #(
  parameter int TW      = 20,
  parameter int ROWW    = 14,
  parameter int ACCW    = 8,
  parameter int T_RAS   = 28,
  parameter int T_RCD   = 10,
  parameter int T_RP    = 10,
  parameter int T_RRD   = 4,
  parameter int T_RRD_L = 6,
  parameter int T_CCD_L = 6,
  parameter int T_BURST = 4,
  parameter int T_CS    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   t,
  input  logic [ROWW-1:0] row,
  input  logic            act_rank,
  input  logic            act_self,
  input  logic            pre_self,
  input  logic            col_any,
  input  logic            col_self,
  input  logic            same_rank,
  input  logic            same_grp,
  input  logic            win_hit,
  input  logic [TW-1:0]   win_floor,
  output logic [TW-1:0]   act_at,
  output logic [TW-1:0]   pre_at,
  output logic [TW-1:0]   col_at,
  output logic [ROWW-1:0] row_q,
  output logic            open_q,
  output logic [ACCW-1:0] acc_q
);
  localparam logic [TW-1:0] RAS_W  = TW'(T_RAS);
  localparam logic [TW-1:0] RCD_W  = TW'(T_RCD);
  localparam logic [TW-1:0] RP_W   = TW'(T_RP);
  localparam logic [TW-1:0] RRD_W  = TW'(T_RRD);
  localparam logic [TW-1:0] RRDL_W = TW'(T_RRD_L);
  localparam logic [TW-1:0] CCDL_W = TW'(T_CCD_L);
  localparam logic [TW-1:0] BST_W  = TW'(T_BURST);
  localparam logic [TW-1:0] XRK_W  = TW'(T_BURST + T_CS);

  function automatic logic [TW-1:0] tmax(logic [TW-1:0] a, logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [TW-1:0]   act_n, pre_n, col_n, col_gap;
  logic [ROWW-1:0] row_n;
  logic            open_n;
  logic [ACCW-1:0] acc_n;

  assign col_gap = !same_rank ? XRK_W : (same_grp ? CCDL_W : BST_W);

  always_comb begin
    act_n  = act_at;
    pre_n  = pre_at;
    col_n  = col_at;
    row_n  = row_q;
    open_n = open_q;
    acc_n  = acc_q;
    if (act_rank) begin
      act_n = tmax(act_n, t + (same_grp ? RRDL_W : RRD_W));
      if (win_hit) act_n = tmax(act_n, win_floor);
    end
    if (act_self) begin
      open_n = 1'b1;
      row_n  = row;
      acc_n  = '0;
      pre_n  = t + RAS_W;
      col_n  = tmax(col_n, t + RCD_W);
    end
    if (pre_self) begin
      open_n = 1'b0;
      act_n  = tmax(act_n, t + RP_W);
    end
    if (col_any) col_n = tmax(col_n, t + col_gap);
    if (col_self) acc_n = acc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_at <= '0;
      pre_at <= '0;
      col_at <= '0;
      row_q  <= '0;
      open_q <= 1'b0;
      acc_q  <= '0;
    end else begin
      act_at <= act_n;
      pre_at <= pre_n;
      col_at <= col_n;
      row_q  <= row_n;
      open_q <= open_n;
      acc_q  <= acc_n;
    end
  end

  p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
    act_self |=> open_q && (row_q == $past(row)) && (acc_q == '0));
  p_pre_closes_r8: assert property (@(posedge clk) disable iff (rst)
    pre_self |=> !open_q);
  p_act_mono_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> act_at >= $past(act_at));
  p_col_mono_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> col_at >= $past(col_at));
endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
  import dbt_pkg::*;
#(
  parameter int NR      = 2,
  parameter int NB      = 8,
  parameter int NBG     = 4,
  parameter int BG_EN   = 1,
  parameter int TW      = 20,
  parameter int ROWW    = 14,
  parameter int ACCW    = 8,
  parameter int XN      = 4,
  parameter int T_RAS   = 28,
  parameter int T_RCD   = 10,
  parameter int T_RP    = 10,
  parameter int T_RRD   = 4,
  parameter int T_RRD_L = 6,
  parameter int T_XAW   = 20,
  parameter int T_CCD_L = 6,
  parameter int T_BURST = 4,
  parameter int T_CS    = 3,
  localparam int RW = (NR > 1) ? $clog2(NR) : 1,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [RW-1:0]   cmd_rank,
  input  logic [BW-1:0]   cmd_bank,
  input  logic [ROWW-1:0] cmd_row,
  input  logic [TW-1:0]   cmd_time,
  input  logic [RW-1:0]   q_rank,
  input  logic [BW-1:0]   q_bank,
  output logic [TW-1:0]   q_act_at,
  output logic [TW-1:0]   q_pre_at,
  output logic [TW-1:0]   q_col_at,
  output logic [ROWW-1:0] q_row,
  output logic            q_open,
  output logic [ACCW-1:0] q_acc,
  output logic [CW-1:0]   q_nact,
  output logic            seq_err,
  output logic            act_window_err
);
  localparam int NT = NR * NB;

  logic [TW-1:0]   act_v [NT];
  logic [TW-1:0]   pre_v [NT];
  logic [TW-1:0]   col_v [NT];
  logic [ROWW-1:0] row_v [NT];
  logic [ACCW-1:0] acc_v [NT];
  logic [NT-1:0]   open_v;
  logic [CW-1:0]   cnt_v [NR];
  logic [NR-1:0]   viol_v;

  logic            is_act, is_pre, is_col, sel_open, act_ok, pre_ok;
  logic [BW-1:0]   cmd_grp;
  int unsigned     sel_idx, q_idx;

  assign sel_idx  = int'(cmd_rank) * NB + int'(cmd_bank);
  assign q_idx    = int'(q_rank) * NB + int'(q_bank);
  assign sel_open = open_v[sel_idx];
  assign is_act   = cmd_valid && (dbt_op_e'(cmd_op) == OP_ACT);
  assign is_pre   = cmd_valid && (dbt_op_e'(cmd_op) == OP_PRE);
  assign is_col   = cmd_valid && (dbt_op_e'(cmd_op) == OP_COL);
  assign act_ok   = is_act && !sel_open;
  assign pre_ok   = is_pre && sel_open;
  assign cmd_grp  = cmd_bank % BW'(NBG);

  for (genvar r = 0; r < NR; r++) begin : g_rank
    logic          rk_sel, w_hit, w_viol;
    logic [TW-1:0] w_floor;
    logic [NB-1:0] rk_open;
    logic [CW-1:0] cnt_q;

    assign rk_sel = (cmd_rank == RW'(r));

    dbt_window #(.TW(TW), .XN(XN), .T_XAW(T_XAW)) u_win (
      .clk(clk), .rst(rst), .push(act_ok && rk_sel), .t(cmd_time),
      .hit(w_hit), .floor_at(w_floor), .viol(w_viol));
    assign viol_v[r] = w_viol;

    for (genvar b = 0; b < NB; b++) begin : g_bank
      localparam int IX = r * NB + b;
      localparam logic [BW-1:0] GB = BW'(b % NBG);
      logic self_hit;
      assign self_hit = rk_sel && (cmd_bank == BW'(b));

      dbt_bank #(
        .TW(TW), .ROWW(ROWW), .ACCW(ACCW), .T_RAS(T_RAS), .T_RCD(T_RCD),
        .T_RP(T_RP), .T_RRD(T_RRD), .T_RRD_L(T_RRD_L), .T_CCD_L(T_CCD_L),
        .T_BURST(T_BURST), .T_CS(T_CS)
      ) u_bank (
        .clk(clk), .rst(rst), .t(cmd_time), .row(cmd_row),
        .act_rank(act_ok && rk_sel), .act_self(act_ok && self_hit),
        .pre_self(pre_ok && self_hit), .col_any(is_col),
        .col_self(is_col && self_hit), .same_rank(rk_sel),
        .same_grp((BG_EN != 0) && (cmd_grp == GB)),
        .win_hit(w_hit), .win_floor(w_floor),
        .act_at(act_v[IX]), .pre_at(pre_v[IX]), .col_at(col_v[IX]),
        .row_q(row_v[IX]), .open_q(open_v[IX]), .acc_q(acc_v[IX]));
      assign rk_open[b] = open_v[IX];
    end

    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else if (act_ok && rk_sel) cnt_q <= cnt_q + 1'b1;
      else if (pre_ok && rk_sel) cnt_q <= cnt_q - 1'b1;
    end
    assign cnt_v[r] = cnt_q;

    p_count_match_r10: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CW'($countones(rk_open))) && (cnt_q <= CW'(NB)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_err        <= 1'b0;
      act_window_err <= 1'b0;
    end else begin
      seq_err        <= (is_act && sel_open) || (is_pre && !sel_open);
      act_window_err <= |viol_v;
    end
  end

  assign q_act_at = act_v[q_idx];
  assign q_pre_at = pre_v[q_idx];
  assign q_col_at = col_v[q_idx];
  assign q_row    = row_v[q_idx];
  assign q_open   = open_v[q_idx];
  assign q_acc    = acc_v[q_idx];
  assign q_nact   = cnt_v[q_rank];

  p_flag_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (is_act && sel_open) |=> seq_err && $stable(open_v));
endmodule

// File: tb/sim_dram_bank_timer.sv
`timescale 1ns/1ps
module sim_dram_bank_timer;
  localparam int NR = 2, NB = 8, NBG = 4, BG_EN = 1, TW = 20, ROWW = 14;
  localparam int ACCW = 8, XN = 4;
  localparam int RAS = 28, RCD = 10, RP = 10, RRD = 4, RRDL = 6, XAW = 20;
  localparam int CCDL = 6, BST = 4, CS = 3;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [0:0] cmd_rank = 0, q_rank = 0;
  logic [2:0] cmd_bank = 0, q_bank = 0;
  logic [ROWW-1:0] cmd_row = 0;
  logic [TW-1:0] cmd_time = 0;
  logic [TW-1:0] q_act_at, q_pre_at, q_col_at;
  logic [ROWW-1:0] q_row;
  logic q_open, seq_err, act_window_err;
  logic [ACCW-1:0] q_acc;
  logic [3:0] q_nact;

  always #2.5 clk = ~clk;

  dram_bank_timer u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_time(cmd_time), .q_rank(q_rank), .q_bank(q_bank),
    .q_act_at(q_act_at), .q_pre_at(q_pre_at), .q_col_at(q_col_at),
    .q_row(q_row), .q_open(q_open), .q_acc(q_acc), .q_nact(q_nact),
    .seq_err(seq_err), .act_window_err(act_window_err));

  int checks = 0, errors = 0;
  int m_act [NR][NB], m_pre [NR][NB], m_col [NR][NB], m_row [NR][NB];
  int m_acc [NR][NB], m_open [NR][NB], m_win [NR][XN], m_cnt [NR];
  int e_seq, e_xaw;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int grp_eq(int a, int b);
    return (BG_EN != 0) && ((a % NBG) == (b % NBG));
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic model(int v, int op, int r, int b, int row, int t);
    e_seq = 0; e_xaw = 0;
    if (!v || op == 0) return;
    if ((op == 1 && m_open[r][b] != 0) || (op == 2 && m_open[r][b] == 0)) begin
      e_seq = 1; return;
    end
    if (op == 1) begin
      int old = m_win[r][XN-1];
      int nxt = m_win[r][XN-2];
      e_xaw = (old != 0) && (t - old < XAW);
      for (int k = 0; k < NB; k++) begin
        m_act[r][k] = imax(m_act[r][k], t + (grp_eq(k, b) ? RRDL : RRD));
        if (nxt != 0 && t - nxt < XAW) m_act[r][k] = imax(m_act[r][k], nxt + XAW);
      end
      for (int k = XN - 1; k > 0; k--) m_win[r][k] = m_win[r][k-1];
      m_win[r][0] = t;
      m_open[r][b] = 1; m_row[r][b] = row; m_acc[r][b] = 0;
      m_pre[r][b] = t + RAS; m_col[r][b] = imax(m_col[r][b], t + RCD);
      m_cnt[r]++;
    end else if (op == 2) begin
      m_open[r][b] = 0;
      m_act[r][b] = imax(m_act[r][b], t + RP);
      m_cnt[r]--;
    end else begin
      for (int r2 = 0; r2 < NR; r2++)
        for (int k = 0; k < NB; k++) begin
          int d = (r2 != r) ? BST + CS : (grp_eq(k, b) ? CCDL : BST);
          m_col[r2][k] = imax(m_col[r2][k], t + d);
        end
      m_acc[r][b] = (m_acc[r][b] + 1) % 256;
    end
  endtask

  task automatic chk_bank(int r, int b);
    q_rank = 1'(r); q_bank = 3'(b);
    #0.5;
    chk("R4 act_at", int'(q_act_at), m_act[r][b]);
    chk("R3 pre_at", int'(q_pre_at), m_pre[r][b]);
    chk("R7 col_at", int'(q_col_at), m_col[r][b]);
    chk("R3 open", int'(q_open), m_open[r][b]);
    if (m_open[r][b] != 0) chk("R3 row", int'(q_row), m_row[r][b]);
    chk("R7 acc", int'(q_acc), m_acc[r][b]);
    chk("R10 count", int'(q_nact), m_cnt[r]);
  endtask

  // Called at a falling edge; returns at the falling edge after the command.
  task automatic do_cmd(int v, int op, int r, int b, int row, int t);
    model(v, op, r, b, row, t);
    cmd_valid = v[0]; cmd_op = 2'(op); cmd_rank = 1'(r); cmd_bank = 3'(b);
    cmd_row = ROWW'(row); cmd_time = TW'(t);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    chk("R9 seq_err", int'(seq_err), e_seq);
    chk("R6 act_window_err", int'(act_window_err), e_xaw);
    chk_bank(r, b);
  endtask

  task automatic peek(string tag, int r, int b, int exp_act);
    q_rank = 1'(r); q_bank = 3'(b);
    #0.5;
    chk(tag, int'(q_act_at), exp_act);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running expected done");
    report();
  end

  initial begin
    int t;
    void'($urandom(32'd1234));
    for (int r = 0; r < NR; r++) begin
      m_cnt[r] = 0;
      for (int k = 0; k < XN; k++) m_win[r][k] = 0;
      for (int b = 0; b < NB; b++) begin
        m_act[r][b] = 0; m_pre[r][b] = 0; m_col[r][b] = 0;
        m_row[r][b] = 0; m_acc[r][b] = 0; m_open[r][b] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 seq_err", int'(seq_err), 0);
    chk("R1 act_window_err", int'(act_window_err), 0);
    chk_bank(0, 0);
    chk_bank(1, 7);

    // R2: group spacing after one activate to rank 0 bank 0 at t=10
    do_cmd(1, 1, 0, 0, 100, 10);
    peek("R2 shared group", 0, 4, 16);
    peek("R2 other group", 0, 1, 14);
    peek("R4 other rank", 1, 4, 0);
    do_cmd(1, 1, 0, 1, 101, 12);
    do_cmd(1, 1, 0, 2, 102, 14);
    do_cmd(1, 1, 0, 3, 103, 16);
    peek("R5 window floor", 0, 6, 30);
    do_cmd(1, 1, 0, 4, 104, 18);          // R6 window exceeded
    chk("R6 flag", int'(act_window_err), 1);
    do_cmd(1, 1, 0, 0, 999, 20);          // R9 activate to open bank
    chk("R9 row kept", int'(q_row), 100);
    do_cmd(1, 2, 0, 0, 0, 40);            // R8 precharge
    peek("R8 act after pre", 0, 0, 50);
    chk("R8 count", int'(q_nact), 4);
    do_cmd(1, 3, 0, 1, 0, 60);            // R7 column spacing
    chk_bank(1, 3);
    q_rank = 1; q_bank = 3; #0.5;
    chk("R7 cross rank", int'(q_col_at), 67);
    q_rank = 0; q_bank = 5; #0.5;
    chk("R7 same group", int'(q_col_at), 66);
    q_rank = 0; q_bank = 2; #0.5;
    chk("R7 other group", int'(q_col_at), 64);
    do_cmd(0, 1, 1, 0, 55, 70);           // R11 valid low
    chk("R11 valid low", int'(q_open), 0);
    do_cmd(1, 0, 1, 0, 55, 72);           // R11 no-op
    chk("R11 no-op", int'(q_open), 0);

    t = 80;
    for (int n = 0; n < 1500; n++) begin
      int r = int'($urandom % NR);
      int b = int'($urandom % NB);
      int op;
      int bad = ($urandom % 16) == 0;
      if (m_open[r][b] != 0) op = bad ? 1 : (($urandom % 3 == 0) ? 2 : 3);
      else op = bad ? 2 : 1;
      t = t + 1 + int'($urandom % 4);
      do_cmd(1, op, r, b, int'($urandom % 16384), t);
      chk_bank(int'($urandom % NR), int'($urandom % NB));
    end
    report();
  end
endmodule